// File: doc/BRIEF.md
# Configurable Multi-Phase Reset Sequencer

This block drives a functional reset through three ordered phases once any of eleven reset-request sources fires. The sources are the external pin, PLL1 loss, flash fatal error, 4.5 V low-voltage detect, clock-monitor frequency fault, oscillator-low fault, PLL0 loss, checkstop, software, core and JTAG. A full sequence runs phase one, then phase two, then phase three. Each phase holds for a parameterised number of cycles, and a dedicated reset-asserted output is high during each phase.

A 16-bit configuration register holds one fast-path bit per source. When the bits of the triggering sources allow it, the sequence skips the first two phases and starts directly in phase three. The register sits behind a simple write-enable bus with a privilege input. Supervisor and test privilege may write it. Writes at any other privilege are dropped and flagged on an error output.

A request that arrives while a sequence is running is remembered. When phase three ends, the sequence starts again for that request. A one-hot cause vector shows which source started the current sequence, and a done pulse marks the return to idle.

Top module: `rst_phase_seq`

## Requirements
- R1: After reset, `phase_o` is 0 (idle), `ph_rst_o`, `cause_o`, `done_o`, `cfg_err_o` are 0 and `cfg_rdata_o` reads 0.
- R2: A request whose fast-path bit is 0 moves `phase_o` through 1, 2 and 3. It holds 1 for PH1_CYC cycles, 2 for PH2_CYC cycles and 3 for PH3_CYC cycles, then returns to 0. `ph_rst_o[k]` is high exactly while `phase_o` equals k+1.
- R3: A request whose fast-path bit is 1 moves `phase_o` from 0 straight to 3 for PH3_CYC cycles, then back to 0. Phases 1 and 2 never appear.
- R4: The fast-path bit for source 0 is register bit 0, and the bit for source k (k ≥ 1) is register bit k+5. Bits 1 to 5 always read 0 and are not changed by writes.
- R5: `cfg_priv_i` encodes 0 as user, 1 as supervisor, 2 as test and 3 as reserved. A write with privilege 1 or 2 updates the register on that clock edge. A write with privilege 0 or 3 leaves it unchanged and raises `cfg_err_o` for exactly the following cycle.
- R6: When several sources request in the same cycle, the short path is taken only if every one of them has its fast-path bit set. Otherwise the full sequence runs.
- R7: A request arriving during a sequence is held. When phase three completes, the sequence restarts with the start phase chosen by the held requests. No done pulse is given at that restart.
- R8: While `phase_o` is non-zero, `cause_o` is one-hot and marks the lowest-indexed source that started the current sequence. In idle it is 0.
- R9: `done_o` is high for exactly one cycle: the first idle cycle after phase three completes with nothing held.
- R10: An idle sequencer samples `req_i` on a clock edge and shows the start phase in `phase_o` from the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 11 | Reset requests, one per source |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_priv_i | input | 2 | Privilege of the access (0 user, 1 supervisor, 2 test, 3 reserved) |
| cfg_wdata_i | input | 16 | Configuration write data |
| cfg_rdata_o | output | 16 | Configuration register contents |
| cfg_err_o | output | 1 | One-cycle pulse after a write that was refused |
| phase_o | output | 2 | Current phase, 0 when idle |
| ph_rst_o | output | 3 | Reset asserted for phase one, two, three |
| cause_o | output | 11 | One-hot cause of the running sequence |
| done_o | output | 1 | One-cycle pulse when the sequence ends |

## Verification
The bench sweeps every source through both the full and the short path, with phase lengths counted cycle by cycle. A design that mapped a fast-path bit to the wrong register position would run the wrong path for that source. One that let a short bit leak to other sources would shorten their sequences. Mixed same-cycle requests catch a design that ORs the fast-path bits where it should AND them. A request raised mid-sequence catches one that drops the request or emits a spurious done. Writes of all ones, and writes under user or reserved privilege, expose reserved bits that hold data and privilege gating that fails to block the write or to raise the error.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  localparam int NSRC   = 11;
  localparam int CFG_W  = 16;
  localparam int RSV_HI = 5;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ONE   = 2'd1,
    PH_TWO   = 2'd2,
    PH_THREE = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    PRIV_USER = 2'd0,
    PRIV_SUP  = 2'd1,
    PRIV_TEST = 2'd2,
    PRIV_RSVD = 2'd3
  } priv_e;

  // register bit that holds the fast-path flag of source k
  function automatic int src_bit(int k);
    return (k == 0) ? 0 : k + RSV_HI;
  endfunction

  function automatic logic [CFG_W-1:0] cfg_mask();
    logic [CFG_W-1:0] m;
    m = '0;
    for (int k = 0; k < NSRC; k++) m[src_bit(k)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/rst_cfg_reg.sv
module rst_cfg_reg
  import rst_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       priv_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] rdata_o,
  output logic [NSRC-1:0]  short_o,
  output logic             err_o
);
  localparam logic [CFG_W-1:0] MASK = cfg_mask();

  logic [CFG_W-1:0] cfg_q;
  logic             err_q;
  logic             allow;

  assign allow = (priv_i == PRIV_SUP) || (priv_i == PRIV_TEST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= we_i && !allow;
      if (we_i && allow) cfg_q <= wdata_i & MASK;
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_short
    localparam int BP = src_bit(g);
    assign short_o[g] = cfg_q[BP];
  end

  assign rdata_o = cfg_q;
  assign err_o   = err_q;
endmodule

// File: rtl/rst_req_eval.sv
module rst_req_eval
  import rst_seq_pkg::*;
(
  input  logic [NSRC-1:0] vec_i,
  input  logic [NSRC-1:0] short_i,
  output logic            any_o,
  output logic            short_o,
  output logic [NSRC-1:0] cause_o
);
  logic [NSRC-1:0] neg;

  assign neg     = ~vec_i + {{(NSRC-1){1'b0}}, 1'b1};
  assign any_o   = |vec_i;
  // fast path only when every requester allows it
  assign short_o = any_o && ((vec_i & ~short_i) == '0);
  assign cause_o = vec_i & neg;
endmodule

// File: rtl/rst_phase_fsm.sv
module rst_phase_fsm
  import rst_seq_pkg::*;
#(
  parameter int PH1_CYC = 4,
  parameter int PH2_CYC = 3,
  parameter int PH3_CYC = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] req_i,
  input  logic            any_i,
  input  logic            short_i,
  input  logic [NSRC-1:0] cause_i,
  output logic [NSRC-1:0] eval_vec_o,
  output phase_e          phase_o,
  output logic [NSRC-1:0] cause_o,
  output logic            done_o
);
  localparam int MAXL = (PH1_CYC > PH2_CYC) ? ((PH1_CYC > PH3_CYC) ? PH1_CYC : PH3_CYC)
                                            : ((PH2_CYC > PH3_CYC) ? PH2_CYC : PH3_CYC);
  localparam int CW = (MAXL > 1) ? $clog2(MAXL) : 1;
  localparam logic [CW-1:0] L1 = CW'(PH1_CYC - 1);
  localparam logic [CW-1:0] L2 = CW'(PH2_CYC - 1);
  localparam logic [CW-1:0] L3 = CW'(PH3_CYC - 1);

  phase_e          st_q;
  logic [CW-1:0]   cnt_q;
  logic [NSRC-1:0] pend_q, cause_q;
  logic            done_q;
  logic            last;

  assign eval_vec_o = (st_q == PH_IDLE) ? req_i : (pend_q | req_i);

  always_comb begin
    unique case (st_q)
      PH_ONE:   last = (cnt_q == L1);
      PH_TWO:   last = (cnt_q == L2);
      PH_THREE: last = (cnt_q == L3);
      default:  last = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= PH_IDLE;
      cnt_q   <= '0;
      pend_q  <= '0;
      cause_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        PH_IDLE: begin
          if (any_i) begin
            st_q    <= short_i ? PH_THREE : PH_ONE;
            cnt_q   <= '0;
            cause_q <= cause_i;
            pend_q  <= '0;
          end
        end
        PH_ONE, PH_TWO: begin
          pend_q <= pend_q | req_i;
          if (last) begin
            st_q  <= (st_q == PH_ONE) ? PH_TWO : PH_THREE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_THREE: begin
          if (last) begin
            cnt_q  <= '0;
            pend_q <= '0;
            if (any_i) begin
              st_q    <= short_i ? PH_THREE : PH_ONE;
              cause_q <= cause_i;
            end else begin
              st_q    <= PH_IDLE;
              cause_q <= '0;
              done_q  <= 1'b1;
            end
          end else begin
            pend_q <= pend_q | req_i;
            cnt_q  <= cnt_q + 1'b1;
          end
        end
        default: st_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = st_q;
  assign cause_o = cause_q;
  assign done_o  = done_q;
endmodule

// File: rtl/rst_phase_seq.sv
module rst_phase_seq
  import rst_seq_pkg::*;
#(
  parameter int PH1_CYC = 4,
  parameter int PH2_CYC = 3,
  parameter int PH3_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  req_i,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_priv_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_rdata_o,
  output logic             cfg_err_o,
  output logic [1:0]       phase_o,
  output logic [2:0]       ph_rst_o,
  output logic [NSRC-1:0]  cause_o,
  output logic             done_o
);
  logic [NSRC-1:0] short_bits, eval_vec, eval_cause;
  logic            eval_any, eval_short;
  phase_e          phase;

  rst_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .priv_i  (cfg_priv_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .short_o (short_bits),
    .err_o   (cfg_err_o)
  );

  rst_req_eval u_eval (
    .vec_i   (eval_vec),
    .short_i (short_bits),
    .any_o   (eval_any),
    .short_o (eval_short),
    .cause_o (eval_cause)
  );

  rst_phase_fsm #(
    .PH1_CYC (PH1_CYC),
    .PH2_CYC (PH2_CYC),
    .PH3_CYC (PH3_CYC)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .any_i      (eval_any),
    .short_i    (eval_short),
    .cause_i    (eval_cause),
    .eval_vec_o (eval_vec),
    .phase_o    (phase),
    .cause_o    (cause_o),
    .done_o     (done_o)
  );

  assign phase_o = phase;
  for (genvar g = 0; g < 3; g++) begin : g_phrst
    assign ph_rst_o[g] = (phase_o == 2'(g + 1));
  end
endmodule

// File: rtl/rst_phase_seq_chk.sv
module rst_phase_seq_chk
  import rst_seq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic [1:0]       cfg_priv_i,
  input logic [CFG_W-1:0] cfg_rdata_o,
  input logic             cfg_err_o,
  input logic [1:0]       phase_o,
  input logic [2:0]       ph_rst_o,
  input logic [NSRC-1:0]  cause_o,
  input logic             done_o
);
  logic refused;
  assign refused = cfg_we_i && (cfg_priv_i != 2'd1) && (cfg_priv_i != 2'd2);

  assert_idle_no_ph2_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd0) |=> (phase_o != 2'd2));
  assert_ph1_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd1) |=> (phase_o == 2'd1 || phase_o == 2'd2));
  assert_ph2_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd2) |=> (phase_o == 2'd2 || phase_o == 2'd3));
  assert_phrst_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ph_rst_o) && ((phase_o == 2'd0) == (ph_rst_o == 3'b000)));
  assert_rsv_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[5:1] == 5'b0);
  assert_refused_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refused |=> $stable(cfg_rdata_o) && cfg_err_o);
  assert_err_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_err_o) |-> $past(refused));
  assert_cause_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o != 2'd0) |-> $onehot(cause_o));
  assert_cause_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd0) |-> (cause_o == '0));
  assert_done_after_ph3_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (phase_o == 2'd0) && ($past(phase_o) == 2'd3));
  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind rst_phase_seq rst_phase_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_priv_i  (cfg_priv_i),
  .cfg_rdata_o (cfg_rdata_o),
  .cfg_err_o   (cfg_err_o),
  .phase_o     (phase_o),
  .ph_rst_o    (ph_rst_o),
  .cause_o     (cause_o),
  .done_o      (done_o)
);

// File: tb/sim_rst_phase_seq.sv
`timescale 1ns/1ps
module sim_rst_phase_seq;
  localparam int NS = 11;
  localparam int P1 = 4, P2 = 3, P3 = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] req = '0;
  logic        we = 1'b0;
  logic [1:0]  priv = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        err;
  logic [1:0]  phase;
  logic [2:0]  phrst;
  logic [10:0] cause;
  logic        done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rst_phase_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .cfg_we_i(we), .cfg_priv_i(priv),
    .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .cfg_err_o(err), .phase_o(phase),
    .ph_rst_o(phrst), .cause_o(cause), .done_o(done)
  );

  function automatic int bpos(int k);
    return (k == 0) ? 0 : k + 5;
  endfunction

  function automatic logic [15:0] legal();
    logic [15:0] m = '0;
    for (int k = 0; k < NS; k++) m[bpos(k)] = 1'b1;
    return m;
  endfunction

  task automatic ck(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [1:0] p, logic [15:0] d);
    priv = p; wdata = d; we = 1'b1;
    tick();
    we = 1'b0;
  endtask

  task automatic start(logic [10:0] v);
    req = v;
    tick();
    req = '0;
  endtask

  task automatic chk_ph(int ph, logic [10:0] c, string rq);
    ck(phase == 2'(ph), rq, 32'(phase), 32'(ph));
    ck(phrst == ((ph == 0) ? 3'b000 : 3'(1 << (ph - 1))), rq, 32'(phrst), 32'(ph));
    ck(cause == c, "R8", 32'(cause), 32'(c));
    ck(done == 1'b0, "R9", 32'(done), 0);
  endtask

  task automatic run_body(bit full, logic [10:0] c, string rq);
    if (full) begin
      for (int i = 0; i < P1; i++) begin chk_ph(1, c, rq); tick(); end
      for (int i = 0; i < P2; i++) begin chk_ph(2, c, rq); tick(); end
    end
    for (int i = 0; i < P3; i++) begin chk_ph(3, c, rq); tick(); end
  endtask

  task automatic chk_end();
    ck(phase == 2'd0, "R2", 32'(phase), 0);
    ck(done == 1'b1, "R9", 32'(done), 1);
    ck(cause == '0, "R8", 32'(cause), 0);
    tick();
    ck(done == 1'b0, "R9", 32'(done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    // R1 reset state
    ck(phase == 0 && phrst == 0 && cause == 0 && done == 0 && err == 0, "R1",
       {phase, phrst, done, err}, 0);
    ck(rdata == 16'h0, "R1", 32'(rdata), 0);

    // R4 / R5 register access sweep
    wr(2'd1, 16'hFFFF);
    ck(rdata == legal(), "R4", 32'(rdata), 32'(legal()));
    ck(err == 1'b0, "R5", 32'(err), 0);
    wr(2'd2, 16'h003E);
    ck(rdata == 16'h0, "R4", 32'(rdata), 0);
    wr(2'd2, 16'hA5A5);
    ck(rdata == (16'hA5A5 & legal()), "R5", 32'(rdata), 32'(16'hA5A5 & legal()));
    wr(2'd0, 16'h0000);
    ck(rdata == (16'hA5A5 & legal()), "R5", 32'(rdata), 32'(16'hA5A5 & legal()));
    ck(err == 1'b1, "R5", 32'(err), 1);
    tick();
    ck(err == 1'b0, "R5", 32'(err), 0);
    wr(2'd3, 16'hFFFF);
    ck(rdata == (16'hA5A5 & legal()), "R5", 32'(rdata), 32'(16'hA5A5 & legal()));
    ck(err == 1'b1, "R5", 32'(err), 1);

    // R2 / R3 / R10 per-source sweep
    for (int k = 0; k < NS; k++) begin
      wr(2'd1, 16'h0);
      start(11'(1 << k));
      ck(phase == 2'd1, "R10", 32'(phase), 1);
      run_body(1'b1, 11'(1 << k), "R2");
      chk_end();
      wr(2'd2, 16'(1 << bpos(k)));
      ck(rdata == 16'(1 << bpos(k)), "R4", 32'(rdata), 32'(1 << bpos(k)));
      start(11'(1 << k));
      ck(phase == 2'd3, "R3", 32'(phase), 3);
      run_body(1'b0, 11'(1 << k), "R3");
      chk_end();
      // another source stays on the full path (R4)
      start(11'(1 << ((k + 1) % NS)));
      run_body(1'b1, 11'(1 << ((k + 1) % NS)), "R4");
      chk_end();
    end

    // R6 simultaneous requests
    wr(2'd1, 16'(1 << bpos(3)));
    start(11'((1 << 3) | (1 << 7)));
    ck(phase == 2'd1, "R6", 32'(phase), 1);
    run_body(1'b1, 11'(1 << 3), "R6");
    chk_end();
    wr(2'd1, 16'((1 << bpos(3)) | (1 << bpos(7))));
    start(11'((1 << 3) | (1 << 7)));
    ck(phase == 2'd3, "R6", 32'(phase), 3);
    run_body(1'b0, 11'(1 << 3), "R6");
    chk_end();
    wr(2'd1, 16'hFFFF);
    start(11'h7FF);
    run_body(1'b0, 11'h001, "R6");
    chk_end();

    // R7 request held during a running sequence
    wr(2'd1, 16'(1 << bpos(5)));
    start(11'(1 << 2));
    for (int i = 0; i < P1; i++) begin chk_ph(1, 11'(1 << 2), "R7"); tick(); end
    chk_ph(2, 11'(1 << 2), "R7");
    req = 11'(1 << 5);
    tick();
    req = '0;
    for (int i = 1; i < P2; i++) begin chk_ph(2, 11'(1 << 2), "R7"); tick(); end
    for (int i = 0; i < P3; i++) begin chk_ph(3, 11'(1 << 2), "R7"); tick(); end
    run_body(1'b0, 11'(1 << 5), "R7");
    chk_end();
    ck(phase == 2'd0, "R7", 32'(phase), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule